// File: doc/BRIEF.md
# Per-Vector Interrupt Routing Controller

This block gathers 256 interrupt inputs for one node and steers each of them to one or more of four cores, on one of eight interrupt lines per core. Every vector has its own pending bit, which a rising edge on its input sets, and its own enable bit. Every vector also has a byte-wide route entry that holds a core bitmap and a node number. The vectors form groups of 32, and a per-group line-select byte picks the output line that the group drives.

Software reaches the block through a flat register port. Writes are 32 bits wide. Reads return 64 bits, registered, one cycle after the address is presented. Pending status is cleared by writing ones. Enable, route, line-select, local-node and a set of eight spare bounce registers are written and read back. Every output line is a plain OR across all qualifying vectors, with no priority between them.

Register addresses (8-bit word addresses):

| Address | Register |
| --- | --- |
| 0x00-0x07 | status, write one to clear (see R3, R4) |
| 0x20-0x27 | enable |
| 0x28-0x2F | bounce |
| 0x30-0x31 | line-select |
| 0x38 | local node |
| 0x40-0x7F | route |

Top module: `vec_route_ctrl`

## Requirements
- R1: Reset (synchronous, active high) clears every pending bit and every configuration register, and drives all outputs to zero.
- R2: A 0-to-1 transition on irq_in[n] sets pending bit n at the next clock edge. An input held high does not set the bit again after the bit has been cleared.
- R3: Reading address w (w = 0..3) returns the 64-bit status word holding vector n at bit n%64 of word n/64. The value appears on rd_data one clock edge after rd_addr is applied. Any unmapped address reads as zero.
- R4: A write to address h (h = 0..7) clears the pending bit of vector 32h+i for every wr_data bit i that is 1. All other pending bits are left unchanged.
- R5: When an input edge and a clear for the same vector occur in the same cycle, the pending bit ends up set.
- R6: Enable register r sits at address 0x20+r. Vector n uses bit n&31 of register n>>5. A vector whose enable bit is 0 never drives any output. Enable registers read back zero-extended.
- R7: The route word for vectors 4w..4w+3 sits at address 0x40+w. Vector n uses byte n&3 of that word. Bits 3:0 of the byte are a core bitmap, and bits 7:4 are a node number. A bitmap with several bits set drives several cores.
- R8: A route entry whose node field differs from the local node register drives no core. The local node register sits at address 0x38, bits 3:0.
- R9: The line-select byte for group g = n>>5 is byte g&3 of the word at address 0x30+(g>>2). irq_out[c*8+k] is 1 when some vector is pending, enabled, routed to core c and in a group whose line-select bit k is 1.
- R10: A write to a route, enable, line-select or node register changes irq_out directly after the clock edge that takes the write. No further cycle of latency is added.
- R11: The bounce registers at 0x28+r store the written value and read it back zero-extended. They have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 256 | Interrupt inputs, one per vector |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read word address |
| rd_data | output | 64 | Registered read data |
| irq_out | output | 32 | Interrupt lines, bit c*8+k is core c line k |

## Verification
A rising edge on an input shows up in the status word and on irq_out right after the next clock edge. A register write shows up on irq_out right after the edge that takes it. rd_data lags the address by exactly one edge. The bench therefore drives every stimulus on a falling edge and samples on the following falling edge, so exactly one rising edge lies between a cause and its check. Two sweeps cover all 256 vectors: one covers capture, clear and the held-level behaviour, and the other covers routing, line selection and enable masking. Expected bit positions in both sweeps are computed from the vector number.

// File: rtl/vrc_pkg.sv
package vrc_pkg;
    localparam int VEC_COUNT  = 256;
    localparam int CORE_COUNT = 4;
    localparam int PIN_COUNT  = 8;
    localparam int GROUP_SIZE = 32;
    localparam int ADDR_W     = 8;

    typedef enum logic [2:0] {
        RG_STAT, RG_EN, RG_BNC, RG_PMAP, RG_NODE, RG_ROUTE, RG_NONE
    } reg_grp_e;

    typedef struct packed {
        reg_grp_e   grp;
        logic [5:0] idx;
    } reg_sel_t;

    typedef struct packed {
        logic [3:0] node;
        logic [3:0] cores;
    } route_ent_t;

    function automatic reg_sel_t reg_decode(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s.idx = a[5:0];
        if (a[7:6] == 2'b01)             s.grp = RG_ROUTE;
        else if (a[7:3] == 5'b00000)     s.grp = RG_STAT;
        else if (a[7:3] == 5'b00100)     s.grp = RG_EN;
        else if (a[7:3] == 5'b00101)     s.grp = RG_BNC;
        else if (a[7:1] == 7'b0011000)   s.grp = RG_PMAP;
        else if (a == 8'h38)             s.grp = RG_NODE;
        else                             s.grp = RG_NONE;
        return s;
    endfunction
endpackage

// File: rtl/vrc_pending.sv
module vrc_pending #(
    parameter int NUM_VEC = vrc_pkg::VEC_COUNT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_VEC-1:0] irq_in,
    input  logic [NUM_VEC-1:0] clr_mask,
    output logic [NUM_VEC-1:0] pend
);
    logic [NUM_VEC-1:0] prev_q;
    logic [NUM_VEC-1:0] rise;

    assign rise = irq_in & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend   <= '0;
        end else begin
            prev_q <= irq_in;
            // a fresh edge overrides a same-cycle clear
            pend   <= (pend & ~clr_mask) | rise;
        end
    end
endmodule

// File: rtl/vrc_cfg.sv
module vrc_cfg
    import vrc_pkg::*;
#(
    parameter int NUM_VEC  = VEC_COUNT,
    parameter int NUM_PINS = PIN_COUNT,
    parameter int GRP_SIZE = GROUP_SIZE
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  reg_sel_t                          wsel,
    input  logic [31:0]                       wr_data,
    input  reg_sel_t                          rsel,
    output logic [31:0]                       rd32,
    output logic [NUM_VEC-1:0]                en_vec,
    output route_ent_t [NUM_VEC-1:0]          route,
    output logic [NUM_VEC/GRP_SIZE-1:0][NUM_PINS-1:0] pmap,
    output logic [3:0]                        node_id
);
    localparam int EN_REGS  = NUM_VEC / 32;
    localparam int RT_WORDS = NUM_VEC / 4;
    localparam int NGRP     = NUM_VEC / GRP_SIZE;
    localparam int PM_WORDS = (NGRP * NUM_PINS + 31) / 32;
    localparam int EN_AW    = $clog2(EN_REGS);
    localparam int RT_AW    = $clog2(RT_WORDS);
    localparam int PM_AW    = (PM_WORDS > 1) ? $clog2(PM_WORDS) : 1;

    logic [EN_REGS-1:0][31:0]  en_q;
    logic [EN_REGS-1:0][31:0]  bnc_q;
    logic [RT_WORDS-1:0][31:0] rt_q;
    logic [PM_WORDS-1:0][31:0] pm_q;
    logic [3:0]                node_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            bnc_q  <= '0;
            rt_q   <= '0;
            pm_q   <= '0;
            node_q <= '0;
        end else if (wr_en) begin
            case (wsel.grp)
                RG_EN:    en_q[wsel.idx[EN_AW-1:0]]  <= wr_data;
                RG_BNC:   bnc_q[wsel.idx[EN_AW-1:0]] <= wr_data;
                RG_ROUTE: rt_q[wsel.idx[RT_AW-1:0]]  <= wr_data;
                RG_PMAP:  pm_q[wsel.idx[PM_AW-1:0]]  <= wr_data;
                RG_NODE:  node_q                     <= wr_data[3:0];
                default:  ;
            endcase
        end
    end

    assign en_vec  = en_q;
    assign route   = rt_q;
    assign pmap    = pm_q[PM_WORDS-1:0];
    assign node_id = node_q;

    always_comb begin
        case (rsel.grp)
            RG_EN:    rd32 = en_q[rsel.idx[EN_AW-1:0]];
            RG_BNC:   rd32 = bnc_q[rsel.idx[EN_AW-1:0]];
            RG_ROUTE: rd32 = rt_q[rsel.idx[RT_AW-1:0]];
            RG_PMAP:  rd32 = pm_q[rsel.idx[PM_AW-1:0]];
            RG_NODE:  rd32 = {28'd0, node_q};
            default:  rd32 = '0;
        endcase
    end
endmodule

// File: rtl/vrc_reduce.sv
module vrc_reduce
    import vrc_pkg::*;
#(
    parameter int NUM_VEC   = VEC_COUNT,
    parameter int NUM_CORES = CORE_COUNT,
    parameter int NUM_PINS  = PIN_COUNT,
    parameter int GRP_SIZE  = GROUP_SIZE
) (
    input  logic [NUM_VEC-1:0]                        pend,
    input  logic [NUM_VEC-1:0]                        en_vec,
    input  route_ent_t [NUM_VEC-1:0]                  route,
    input  logic [NUM_VEC/GRP_SIZE-1:0][NUM_PINS-1:0] pmap,
    input  logic [3:0]                                node_id,
    output logic [NUM_CORES*NUM_PINS-1:0]             irq_out
);
    localparam int NGRP = NUM_VEC / GRP_SIZE;

    logic [NUM_VEC-1:0]                  live;
    logic [NUM_CORES-1:0][NUM_VEC-1:0]   hit;
    logic [NUM_CORES-1:0][NGRP-1:0]      grp_any;

    assign live = pend & en_vec;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
            assign hit[c][v] = live[v] & route[v].cores[c] & (route[v].node == node_id);
        end
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            assign grp_any[c][g] = |hit[c][g*GRP_SIZE +: GRP_SIZE];
        end
    end

    always_comb begin
        irq_out = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            for (int k = 0; k < NUM_PINS; k++) begin
                for (int g = 0; g < NGRP; g++) begin
                    irq_out[c*NUM_PINS+k] = irq_out[c*NUM_PINS+k] | (grp_any[c][g] & pmap[g][k]);
                end
            end
        end
    end
endmodule

// File: rtl/vec_route_ctrl.sv
module vec_route_ctrl
    import vrc_pkg::*;
#(
    parameter int NUM_VEC   = VEC_COUNT,
    parameter int NUM_CORES = CORE_COUNT,
    parameter int NUM_PINS  = PIN_COUNT,
    parameter int GRP_SIZE  = GROUP_SIZE
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_VEC-1:0]            irq_in,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [31:0]                   wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [63:0]                   rd_data,
    output logic [NUM_CORES*NUM_PINS-1:0] irq_out
);
    localparam int HALVES     = NUM_VEC / 32;
    localparam int STAT_WORDS = NUM_VEC / 64;
    localparam int NGRP       = NUM_VEC / GRP_SIZE;

    reg_sel_t                     wsel, rsel;
    logic [NUM_VEC-1:0]           clr_mask;
    logic [NUM_VEC-1:0]           pend;
    logic [NUM_VEC-1:0]           en_vec;
    route_ent_t [NUM_VEC-1:0]     route;
    logic [NGRP-1:0][NUM_PINS-1:0] pmap;
    logic [3:0]                   node_id;
    logic [31:0]                  rd32;
    logic [63:0]                  rd_next;

    assign wsel = reg_decode(wr_addr);
    assign rsel = reg_decode(rd_addr);

    always_comb begin
        clr_mask = '0;
        if (wr_en && wsel.grp == RG_STAT) begin
            for (int h = 0; h < HALVES; h++) begin
                if (wsel.idx == 6'(h)) clr_mask[h*32 +: 32] = wr_data;
            end
        end
    end

    vrc_pending #(.NUM_VEC(NUM_VEC)) u_pend (
        .clk(clk), .rst(rst), .irq_in(irq_in), .clr_mask(clr_mask), .pend(pend)
    );

    vrc_cfg #(.NUM_VEC(NUM_VEC), .NUM_PINS(NUM_PINS), .GRP_SIZE(GRP_SIZE)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wsel(wsel), .wr_data(wr_data),
        .rsel(rsel), .rd32(rd32), .en_vec(en_vec), .route(route),
        .pmap(pmap), .node_id(node_id)
    );

    vrc_reduce #(
        .NUM_VEC(NUM_VEC), .NUM_CORES(NUM_CORES), .NUM_PINS(NUM_PINS), .GRP_SIZE(GRP_SIZE)
    ) u_red (
        .pend(pend), .en_vec(en_vec), .route(route), .pmap(pmap),
        .node_id(node_id), .irq_out(irq_out)
    );

    always_comb begin
        rd_next = {32'd0, rd32};
        if (rsel.grp == RG_STAT) begin
            rd_next = '0;
            for (int w = 0; w < STAT_WORDS; w++) begin
                if (rsel.idx == 6'(w)) rd_next = pend[w*64 +: 64];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= rd_next;
    end
endmodule

// File: rtl/vrc_chk.sv
module vrc_chk #(
    parameter int NUM_VEC = 256,
    parameter int OUT_W   = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_VEC-1:0] irq_in,
    input logic               wr_en,
    input logic [OUT_W-1:0]   irq_out,
    input logic [NUM_VEC-1:0] pend,
    input logic [NUM_VEC-1:0] en_vec
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pend == '0 && irq_out == '0));

    // R4
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (($past(pend) & ~pend) == '0));

    // R6
    gate_off_chk: assert property (@(posedge clk) disable iff (rst)
        ((pend & en_vec) == '0) |-> (irq_out == '0));

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_edge
        // R2
        edge_set_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(irq_in[i]) |=> pend[i]);
    end
endmodule

bind vec_route_ctrl vrc_chk #(.NUM_VEC(NUM_VEC), .OUT_W(NUM_CORES*NUM_PINS)) u_chk (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en),
    .irq_out(irq_out), .pend(pend), .en_vec(en_vec)
);

// File: tb/vec_route_ctrl_tb.sv
module vec_route_ctrl_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [255:0] irq_in = '0;
    logic         wr_en = 1'b0;
    logic [7:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [7:0]   rd_addr = '0;
    logic [63:0]  rd_data;
    logic [31:0]  irq_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    vec_route_ctrl u_dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called on a falling edge, returns on the next falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        rd_addr = a;
        @(negedge clk);
        d = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 out", 64'(irq_out), 64'd0);
        for (int w = 0; w < 4; w++) begin
            rd(8'(w), d); check("R1 status", d, 64'd0);
        end
        rd(8'h20, d); check("R1 enable", d, 64'd0);
        rd(8'h40, d); check("R1 route", d, 64'd0);
        rd(8'h30, d); check("R1 linesel", d, 64'd0);

        // R2 R3 R4 capture and clear sweep over all vectors
        for (int v = 0; v < 256; v++) begin
            irq_in[v] = 1'b1;
            @(negedge clk);
            rd(8'(v/64), d); check("R2 R3 capture", d, 64'd1 << (v%64));
            wr(8'(v/32), 32'd1 << (v%32));
            rd(8'(v/64), d); check("R4 R2 cleared, level held", d, 64'd0);
            irq_in[v] = 1'b0;
        end

        // R4 selective clear
        irq_in[0] = 1'b1; irq_in[1] = 1'b1; irq_in[33] = 1'b1;
        @(negedge clk);
        wr(8'h00, 32'h1);
        rd(8'h00, d); check("R4 selective", d, (64'd1 << 1) | (64'd1 << 33));
        wr(8'h00, 32'h2); wr(8'h01, 32'h2);
        irq_in[0] = 1'b0; irq_in[1] = 1'b0; irq_in[33] = 1'b0;
        rd(8'h00, d); check("R4 all cleared", d, 64'd0);

        // R5 set beats same-cycle clear
        irq_in[7] = 1'b1;
        wr(8'h00, 32'h80);
        rd(8'h00, d); check("R5 set wins", d, 64'h80);
        wr(8'h00, 32'h80);
        irq_in[7] = 1'b0;

        // R3 unmapped reads
        rd(8'hFF, d); check("R3 unmapped", d, 64'd0);
        rd(8'h39, d); check("R3 unmapped", d, 64'd0);

        // configure: all enabled, group g on line g, vector v to core v%4
        for (int r = 0; r < 8; r++) wr(8'(8'h20 + r), 32'hFFFF_FFFF);
        wr(8'h30, 32'h0804_0201);
        wr(8'h31, 32'h8040_2010);
        for (int w = 0; w < 64; w++) wr(8'(8'h40 + w), 32'h0804_0201);
        rd(8'h31, d); check("R9 linesel readback", d, 64'h8040_2010);
        rd(8'h7F, d); check("R7 route readback", d, 64'h0804_0201);

        // R9 R6 routing sweep
        for (int v = 0; v < 256; v++) begin
            irq_in[v] = 1'b1;
            @(negedge clk);
            check("R9 route", 64'(irq_out), 64'(32'd1 << ((v%4)*8 + v/32)));
            wr(8'(8'h20 + v/32), ~(32'd1 << (v%32)));
            check("R6 masked", 64'(irq_out), 64'd0);
            wr(8'(8'h20 + v/32), 32'hFFFF_FFFF);
            check("R10 unmask", 64'(irq_out), 64'(32'd1 << ((v%4)*8 + v/32)));
            wr(8'(v/32), 32'd1 << (v%32));
            check("R4 out cleared", 64'(irq_out), 64'd0);
            irq_in[v] = 1'b0;
        end

        // R6 enable readback
        wr(8'h23, 32'h1234_5678);
        rd(8'h23, d); check("R6 enable readback", d, 64'h1234_5678);
        wr(8'h23, 32'hFFFF_FFFF);

        // R7 multi-hot core bitmap on vector 5
        wr(8'h41, 32'h0000_0F00);
        irq_in[5] = 1'b1;
        @(negedge clk);
        check("R7 multi-hot", 64'(irq_out), 64'h0101_0101);

        // R8 node mismatch, then matching local node
        wr(8'h41, 32'h0000_1100);
        check("R8 foreign node", 64'(irq_out), 64'd0);
        wr(8'h38, 32'h1);
        check("R8 local node", 64'(irq_out), 64'h1);
        rd(8'h38, d); check("R8 node readback", d, 64'h1);
        wr(8'h38, 32'h0);

        // R10 route change seen right after the write edge
        wr(8'h41, 32'h0000_0200);
        check("R10 reroute", 64'(irq_out), 64'h100);

        // R9 multi-hot line select for group 0
        wr(8'h30, 32'h0804_0281);
        check("R9 two lines", 64'(irq_out), 64'h8100);
        wr(8'h30, 32'h0804_0201);

        // R11 bounce store, readback, no output effect
        for (int r = 0; r < 8; r++) wr(8'(8'h28 + r), 32'hA5A5_A5A5 ^ (32'h1111_1111 * r));
        check("R11 no effect", 64'(irq_out), 64'h100);
        for (int r = 0; r < 8; r++) begin
            rd(8'(8'h28 + r), d);
            check("R11 bounce", d, 64'(32'hA5A5_A5A5 ^ (32'h1111_1111 * r)));
        end

        // R6 everything disabled
        for (int r = 0; r < 8; r++) wr(8'(8'h20 + r), 32'd0);
        check("R6 all off", 64'(irq_out), 64'd0);
        irq_in[5] = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule